// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sequences the two switches of one synchronous buck half-bridge. It takes a logic PWM command and produces a high-side enable and a low-side enable. It does not use a fixed dead time. Each switch turns on only after a digitized comparator flag shows that the opposite switch has really turned off. One flag reports that the low-side gate has fallen below its threshold. The other flag reports that the switch node has fallen below its threshold.

Two timers cover the cases where that feedback does not arrive or becomes stale. The first is a refresh timer. It turns the low side on anyway when the switch node fails to fall in time, so the bootstrap capacitor still gets recharged. The second is a diode-emulation timer. It removes the low-side enable when the switch node stays high for too long while the low side is on, and the block then parks with both switches off until the next rising PWM edge.

A supply-good input gates all activity. A shutdown request forces both enables off at once; when it is released, sequencing restarts from the current PWM level. All inputs are assumed to be synchronous to the clock, and all outputs are registered.

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, both enables are 0 and the state output is 0 (idle).
- R2: When the supply-good input is 0, both enables are 0 and the state is idle from the next clock edge on. This holds for as long as supply-good stays 0.
- R3: After PWM goes high, the low-side enable is 0 from the next edge and the state is 1 (waiting for high side). The high-side enable turns on one edge after the low-side-gate-below-threshold flag is seen as 1, and the state becomes 2.
- R4: After PWM goes low, the high-side enable is 0 from the next edge and the state is 3 (waiting for low side). The low-side enable turns on one edge after the switch-node-high flag is seen as 0, and the state becomes 4.
- R5: If the switch-node flag stays 1 during the wait for the low side, the low-side enable turns on exactly REFRESH_CYC edges after the state first became 3.
- R6: While the low side is on, if the switch-node flag is 1 on DIODE_CYC consecutive edges, the low-side enable drops on the last of them and the state becomes 5 (parked).
- R7: A single cycle with the switch-node flag at 0 restarts the count of R6 from zero.
- R8: In the parked state both enables stay 0 for as long as PWM stays low, whatever the flags do. A rising PWM edge moves the state to 1.
- R9: A shutdown request of 1 makes both enables 0 and the state idle at the next edge. After release, the state goes to 1 if PWM is high and to 3 if PWM is low.
- R10: The two enables are never 1 in the same cycle.
- R11: The state output is encoded as follows: 0 idle, 1 waiting for high side, 2 high side on, 3 waiting for low side, 4 low side on, 5 parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | 1 | PWM command; 1 requests the high side |
| lg_low_i | input | 1 | 1 when the low-side gate is below its turn-off threshold |
| sw_high_i | input | 1 | 1 when the switch node is above its threshold |
| pwr_ok_i | input | 1 | Supply-good flag |
| shdn_i | input | 1 | Shutdown request |
| hs_en_o | output | 1 | High-side gate enable (registered) |
| ls_en_o | output | 1 | Low-side gate enable (registered) |
| state_o | output | 3 | Sequencer state, encoded as in R11 |

## Verification
A wrong state shows at the ports within one clock edge, because the enables and the state code are registered straight from the next-state decode. An enable that turns on before its feedback flag, or a state code that differs from the bench model, appears in the cycle right after the stimulus. Timer faults show as a low-side turn-on or a cutoff that lands an edge early or late. Directed counts at exactly the limit and one short of it expose these, and a bench model compared on every cycle of a long random run catches errors in the ordering.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_HI = 3'd1,
    ST_HI_ON   = 3'd2,
    ST_WAIT_LO = 3'd3,
    ST_LO_ON   = 3'd4,
    ST_PARK    = 3'd5
  } seq_st_t;
endpackage

// File: rtl/hb_dwell_timer.sv
// Counts consecutive cycles with run_i high; done_o flags the LIMIT-th one.
module hb_dwell_timer #(
  parameter int LIMIT = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done_o = run_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt <= '0;
    else if (!done_o)  cnt <= cnt + 1'b1;
  end

  // R5/R6: the count never passes the terminal value
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/hb_seq_fsm.sv
module hb_seq_fsm
  import hb_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    pwm_i,
  input  logic    lg_low_i,
  input  logic    sw_high_i,
  input  logic    pwr_ok_i,
  input  logic    shdn_i,
  input  logic    ref_done_i,
  input  logic    de_done_i,
  output seq_st_t st_o,
  output logic    hs_en_o,
  output logic    ls_en_o
);
  seq_st_t st_q, st_d;
  logic    pwm_q;
  logic    pwm_rise;

  assign pwm_rise = pwm_i && !pwm_q;
  assign st_o     = st_q;

  always_comb begin
    st_d = st_q;
    if (!pwr_ok_i || shdn_i) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:    st_d = pwm_i ? ST_WAIT_HI : ST_WAIT_LO;
        ST_WAIT_HI: if (!pwm_i) st_d = ST_WAIT_LO;
                    else if (lg_low_i) st_d = ST_HI_ON;
        ST_HI_ON:   if (!pwm_i) st_d = ST_WAIT_LO;
        ST_WAIT_LO: if (pwm_i) st_d = ST_WAIT_HI;
                    else if (!sw_high_i || ref_done_i) st_d = ST_LO_ON;
        ST_LO_ON:   if (pwm_i) st_d = ST_WAIT_HI;
                    else if (de_done_i) st_d = ST_PARK;
        ST_PARK:    if (pwm_rise) st_d = ST_WAIT_HI;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pwm_q   <= 1'b0;
      hs_en_o <= 1'b0;
      ls_en_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      pwm_q   <= pwm_i;
      hs_en_o <= (st_d == ST_HI_ON);
      ls_en_o <= (st_d == ST_LO_ON);
    end
  end

  // R10: never both switches enabled
  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(hs_en_o && ls_en_o));
  // R2: supply loss clears both enables at the next edge
  assert_pwr_off_R2: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok_i |=> (!hs_en_o && !ls_en_o));
  // R9: shutdown clears both enables at the next edge
  assert_shdn_off_R9: assert property (@(posedge clk) disable iff (rst)
    shdn_i |=> (!hs_en_o && !ls_en_o && st_q == ST_IDLE));
  // R3: high side only rises after the low-side gate flag was seen
  assert_hs_gate_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en_o) |-> $past(lg_low_i));
  // R4/R5: low side only rises on a low node or the refresh timeout
  assert_ls_gate_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en_o) |-> $past(!sw_high_i || ref_done_i));
  // R6: diode-emulation timeout removes the low-side enable
  assert_de_cut_R6: assert property (@(posedge clk) disable iff (rst)
    de_done_i |=> !ls_en_o);
  // R8: parked with PWM low keeps both enables off
  assert_park_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PARK && !pwm_i) |=> (!hs_en_o && !ls_en_o));
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_seq_pkg::*;
#(
  parameter int REFRESH_CYC = 25,
  parameter int DIODE_CYC   = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwm_i,
  input  logic       lg_low_i,
  input  logic       sw_high_i,
  input  logic       pwr_ok_i,
  input  logic       shdn_i,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic [2:0] state_o
);
  seq_st_t st;
  logic    ref_run, ref_done;
  logic    de_run, de_done;

  assign ref_run = (st == ST_WAIT_LO);
  assign de_run  = (st == ST_LO_ON) && sw_high_i;
  assign state_o = st;

  hb_dwell_timer #(.LIMIT(REFRESH_CYC)) u_ref_tmr (
    .clk(clk), .rst(rst), .run_i(ref_run), .done_o(ref_done)
  );

  hb_dwell_timer #(.LIMIT(DIODE_CYC)) u_de_tmr (
    .clk(clk), .rst(rst), .run_i(de_run), .done_o(de_done)
  );

  hb_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .pwm_i(pwm_i), .lg_low_i(lg_low_i),
    .sw_high_i(sw_high_i), .pwr_ok_i(pwr_ok_i), .shdn_i(shdn_i),
    .ref_done_i(ref_done), .de_done_i(de_done),
    .st_o(st), .hs_en_o(hs_en_o), .ls_en_o(ls_en_o)
  );
endmodule

// File: tb/sim_hb_gate_seq.sv
module sim_hb_gate_seq;
  localparam int CLK_NS = 10;
  localparam int REF    = 5;
  localparam int DE     = 12;

  logic clk = 0, rst = 1;
  logic pwm = 0, lgl = 0, swh = 1, ok = 0, sd = 0;
  logic hs, ls;
  logic [2:0] st;
  int ncmp = 0, nbad = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  hb_gate_seq #(.REFRESH_CYC(REF), .DIODE_CYC(DE)) u0 (
    .clk(clk), .rst(rst), .pwm_i(pwm), .lg_low_i(lgl), .sw_high_i(swh),
    .pwr_ok_i(ok), .shdn_i(sd), .hs_en_o(hs), .ls_en_o(ls), .state_o(st)
  );

  // Bench model built from the requirements
  int m_st = 0, m_r = 0, m_d = 0;
  bit m_pq = 0;
  always @(posedge clk) begin
    int nst;
    bit rdone, ddone;
    if (rst) begin
      m_st = 0; m_r = 0; m_d = 0; m_pq = 0;
    end else begin
      nst   = m_st;
      rdone = (m_st == 3) && (m_r + 1 >= REF);
      ddone = (m_st == 4) && swh && (m_d + 1 >= DE);
      if (!ok || sd) nst = 0;
      else case (m_st)
        0: nst = pwm ? 1 : 3;
        1: if (!pwm) nst = 3; else if (lgl) nst = 2;
        2: if (!pwm) nst = 3;
        3: if (pwm) nst = 1; else if (!swh || rdone) nst = 4;
        4: if (pwm) nst = 1; else if (ddone) nst = 5;
        5: if (pwm && !m_pq) nst = 1;
        default: nst = 0;
      endcase
      m_r  = (m_st == 3) ? m_r + 1 : 0;
      m_d  = (m_st == 4 && swh) ? m_d + 1 : 0;
      m_pq = pwm;
      m_st = nst;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string tag, logic eh, logic el, logic [2:0] es);
    ncmp++;
    if (hs !== eh || ls !== el || st !== es) begin
      nbad++;
      $display("FAIL %s hs/ls/state act %b/%b/%0d exp %b/%b/%0d",
               tag, hs, ls, st, eh, el, es);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      ncmp++; nbad++;
      $display("FAIL watchdog act hung exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(3);
    chk("R1 in reset", 0, 0, 0);
    rst = 0; ok = 0; pwm = 1; lgl = 1;
    tick(1); chk("R1 after reset", 0, 0, 0);
    tick(2); chk("R2 no supply", 0, 0, 0);
    ok = 1; lgl = 0;
    tick(1); chk("R3 wait hs", 0, 0, 1);
    tick(2); chk("R3 hold without flag", 0, 0, 1);
    lgl = 1;
    tick(1); chk("R3 hs on", 1, 0, 2);
    pwm = 0; swh = 1;
    tick(1); chk("R4 hs off first", 0, 0, 3);
    swh = 0;
    tick(1); chk("R4 ls on", 0, 1, 4);
    pwm = 1; lgl = 0;
    tick(1); chk("R3 ls off first", 0, 0, 1);
    lgl = 1;
    tick(1); chk("R3 hs on again", 1, 0, 2);
    // refresh timeout
    pwm = 0; swh = 1;
    tick(1); chk("R4 entry wait", 0, 0, 3);
    tick(REF - 1); chk("R5 one short", 0, 0, 3);
    tick(1); chk("R5 refresh ls on", 0, 1, 4);
    // diode emulation with restart
    tick(DE - 2); chk("R6 below limit", 0, 1, 4);
    swh = 0;
    tick(1); chk("R7 node low", 0, 1, 4);
    swh = 1;
    tick(DE - 1); chk("R7 count restarted", 0, 1, 4);
    tick(1); chk("R6 cutoff", 0, 0, 5);
    swh = 0; tick(3); chk("R8 parked node low", 0, 0, 5);
    swh = 1; tick(3); chk("R8 parked node high", 0, 0, 5);
    pwm = 1; lgl = 1;
    tick(1); chk("R8 rising leaves park", 0, 0, 1);
    tick(1); chk("R11 hs state", 1, 0, 2);
    // shutdown
    sd = 1;
    tick(1); chk("R9 shutdown", 0, 0, 0);
    tick(2); chk("R9 held", 0, 0, 0);
    sd = 0;
    tick(1); chk("R9 resume high", 0, 0, 1);
    tick(1); chk("R9 hs after resume", 1, 0, 2);
    sd = 1; tick(1);
    sd = 0; pwm = 0; swh = 0;
    tick(1); chk("R9 resume low", 0, 0, 3);
    tick(1); chk("R9 ls after resume", 0, 1, 4);
    ok = 0;
    tick(1); chk("R2 supply lost", 0, 0, 0);
    tick(3); chk("R2 stays low", 0, 0, 0);
    ok = 1;
    tick(1); chk("R2 restored", 0, 0, 3);
    // random phase against the model
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) pwm = ~pwm;
      lgl = ($urandom_range(2) != 0);
      swh = ($urandom_range(4) != 0);
      sd  = ($urandom_range(150) == 0);
      ok  = ($urandom_range(300) != 0);
      tick(1);
      chk("R11 model", m_st == 2, m_st == 4, 3'(m_st));
      ncmp++;
      if (hs && ls) begin
        nbad++;
        $display("FAIL R10 act hs=1 ls=1 exp not both");
      end
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule